// File: doc/BRIEF.md
# CPU bus address decoder

This block sits on an 8-bit processor's 16-bit address bus and steers every read or write strobe to exactly one target. The lowest 8 KiB of the map reach a 2 KiB work RAM held inside the block, which appears four times. The next 8 KiB reach a bank of eight graphics-controller register ports, which appears every eight bytes. A 32-byte I/O window follows, holding one address that starts a DMA transfer. Everything above the I/O window goes to an external cartridge port without change.

The graphics register ports have per-index permissions. A read or write that a port does not allow never reaches the graphics controller. Such an access returns zero on a read and sets a sticky error flag, which only reset clears.

Strobes toward the graphics controller and the cartridge are combinational in the request cycle. Read data comes back on the bus one cycle after the read strobe. It is chosen by a target select registered in the request cycle, and a target is expected to present its data in that following cycle. The graphics controller, the DMA engine and the cartridge logic are outside the block.

Top module: `cpu_bus_router`

## Requirements
- R1: Addresses 0x0000 to 0x1FFF access the internal 2 KiB RAM at index addr[10:0], so the four 0x800-byte copies alias the same storage, and a RAM read returns its data on bus_rdata in the cycle after the read strobe.
- R2: Addresses 0x2000 to 0x3FFF address the graphics ports, with gfx_idx equal to addr[2:0] and the strobe raised combinationally in the request cycle, so the bank repeats every 8 bytes.
- R3: Only port indices 2, 4 and 7 are readable. A read of one of these raises gfx_rd, and bus_rdata returns gfx_rdata in the next cycle. A read of any other index raises no strobe and returns 0.
- R4: Every port index except 2 is writable, with gfx_wr raised and the data on gfx_wdata. A write to index 2 raises no strobe.
- R5: access_err starts at 0 after reset. It goes to 1 in the cycle after a forbidden port read or write. It then stays at 1 until the next reset.
- R6: A write to exactly 0x4014 raises dma_start for exactly the following cycle, with dma_page holding the written byte.
- R7: Reads of 0x4000 to 0x401F return 0. Writes there raise no strobe on any port, and they change no RAM content. Apart from 0x4014, they also raise no DMA pulse.
- R8: For addresses 0x4020 to 0xFFFF, cart_addr equals the bus address and cart_rd or cart_wr follows the bus strobe. A read returns cart_rdata in the next cycle. Below 0x4020 the cartridge strobes stay low.
- R9: bus_rdata is 0 in any cycle that does not follow a cycle with a read strobe.
- R10: When bus_rd and bus_wr are high together, the access is a write only. No read strobe reaches any target, and bus_rdata is 0 in the next cycle.
- R11: While reset is held and just after it is released, all strobes, dma_start, access_err and bus_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| gfx_idx | output | 3 | Graphics port index |
| gfx_rd | output | 1 | Graphics port read strobe |
| gfx_wr | output | 1 | Graphics port write strobe |
| gfx_wdata | output | 8 | Graphics port write data |
| gfx_rdata | input | 8 | Graphics port read data, one cycle after gfx_rd |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_page | output | 8 | Page byte for the DMA transfer |
| cart_addr | output | 16 | Cartridge address |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data, one cycle after cart_rd |
| access_err | output | 1 | Sticky illegal graphics-port access flag |

## Verification
The bench sweeps every address of the graphics window with both a read and a write. A decoder that took the index from the wrong bits, or mixed up the read and write permission sets, would strobe a forbidden port or leak gfx_rdata onto the bus. RAM is written through one mirror and read back through another, which exposes a decoder that folds too few or too many address bits. The edges at 0x1FFF/0x2000, 0x3FFF/0x4000, 0x401F/0x4020 and the single DMA address are hit directly, so an off-by-one boundary would strobe the cartridge or drop a DMA pulse. Simultaneous read and write strobes and the forbidden-write index check that a wrong priority or a missing gate leaves a read strobe or an unset error flag.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Target selected for a bus access
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_GFX  = 2'd2,
    TGT_CART = 2'd3
  } cbr_tgt_e;

  // Decoded request for one cycle
  typedef struct packed {
    cbr_tgt_e tgt;    // region hit by the address
    logic     rd_go;  // permitted read toward tgt
    logic     wr_go;  // permitted write toward tgt
    logic     dma;    // write to the DMA trigger address
    logic     bad;    // forbidden graphics-port access
  } cbr_dec_t;

endpackage

// File: rtl/cbr_rst_sync.sv
module cbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/cbr_addr_decode.sv
module cbr_addr_decode
  import cbr_pkg::*;
#(
  parameter int                      ADDR_W    = 16,
  parameter int                      REG_AW    = 3,
  parameter logic [ADDR_W-1:0]       REG_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0]       IO_BASE   = 16'h4000,
  parameter logic [ADDR_W-1:0]       CART_BASE = 16'h4020,
  parameter logic [ADDR_W-1:0]       DMA_ADDR  = 16'h4014,
  parameter logic [(1<<REG_AW)-1:0]  RD_MASK   = 8'b1001_0100,
  parameter logic [(1<<REG_AW)-1:0]  WR_MASK   = 8'b1111_1011
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output cbr_dec_t          dec_o
);

  logic              rd_act;
  logic              wr_act;
  logic [REG_AW-1:0] idx;
  logic              rd_ok;
  logic              wr_ok;

  always_comb begin
    // write takes priority when both strobes are high (R10)
    wr_act = wr_i;
    rd_act = rd_i & ~wr_i;
    idx    = addr_i[REG_AW-1:0];
    rd_ok  = RD_MASK[idx];
    wr_ok  = WR_MASK[idx];

    dec_o.tgt   = TGT_NONE;
    dec_o.rd_go = 1'b0;
    dec_o.wr_go = 1'b0;
    dec_o.dma   = 1'b0;
    dec_o.bad   = 1'b0;

    if (addr_i < REG_BASE) begin
      dec_o.tgt   = TGT_RAM;
      dec_o.rd_go = rd_act;
      dec_o.wr_go = wr_act;
    end else if (addr_i < IO_BASE) begin
      dec_o.tgt   = TGT_GFX;
      dec_o.rd_go = rd_act & rd_ok;
      dec_o.wr_go = wr_act & wr_ok;
      dec_o.bad   = (rd_act & ~rd_ok) | (wr_act & ~wr_ok);
    end else if (addr_i < CART_BASE) begin
      dec_o.tgt   = TGT_NONE;
      dec_o.dma   = wr_act & (addr_i == DMA_ADDR);
    end else begin
      dec_o.tgt   = TGT_CART;
      dec_o.rd_go = rd_act;
      dec_o.wr_go = wr_act;
    end
  end

endmodule

// File: rtl/cbr_ram.sv
module cbr_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) q <= mem[addr_i];
  end

  assign rdata_o = q;

  // decoder never asks for a read and a write together (R10)
  always_ff @(posedge clk) begin
    a_no_we_re_r10: assert (!(we_i && re_i))
      else $error("RAM read and write in one cycle");
  end

endmodule

// File: rtl/cbr_dma_trig.sv
module cbr_dma_trig #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [DW-1:0] data_i,
  output logic          pulse_o,
  output logic [DW-1:0] page_o
);

  logic          pulse_q;
  logic          pulse_d;
  logic [DW-1:0] page_q;
  logic [DW-1:0] page_d;
  logic          page_en;

  always_comb begin
    pulse_d = fire_i;
    page_en = fire_i;
    page_d  = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  assign pulse_o = pulse_q;
  assign page_o  = page_q;

  // page byte only changes together with a pulse (R6)
  p_page_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_q) |-> pulse_q)
    else $error("DMA page changed without a pulse");

endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
  import cbr_pkg::*;
#(
  parameter int                      ADDR_W    = 16,
  parameter int                      DATA_W    = 8,
  parameter int                      RAM_AW    = 11,
  parameter int                      REG_AW    = 3,
  parameter logic [ADDR_W-1:0]       REG_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0]       IO_BASE   = 16'h4000,
  parameter logic [ADDR_W-1:0]       CART_BASE = 16'h4020,
  parameter logic [ADDR_W-1:0]       DMA_ADDR  = 16'h4014,
  parameter logic [(1<<REG_AW)-1:0]  RD_MASK   = 8'b1001_0100,
  parameter logic [(1<<REG_AW)-1:0]  WR_MASK   = 8'b1111_1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        gfx_idx,
  output logic              gfx_rd,
  output logic              gfx_wr,
  output logic [7:0]        gfx_wdata,
  input  logic [7:0]        gfx_rdata,
  output logic              dma_start,
  output logic [7:0]        dma_page,
  output logic [15:0]       cart_addr,
  output logic              cart_rd,
  output logic              cart_wr,
  output logic [7:0]        cart_wdata,
  input  logic [7:0]        cart_rdata,
  output logic              access_err
);

  logic        rst_n_s;
  cbr_dec_t    dec;
  cbr_tgt_e    sel_q;
  cbr_tgt_e    sel_d;
  logic        err_q;
  logic        err_d;
  logic        ram_we;
  logic        ram_re;
  logic [DATA_W-1:0] ram_q;

  cbr_rst_sync #(.STAGES(2)) i_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cbr_addr_decode #(
    .ADDR_W   (ADDR_W),
    .REG_AW   (REG_AW),
    .REG_BASE (REG_BASE),
    .IO_BASE  (IO_BASE),
    .CART_BASE(CART_BASE),
    .DMA_ADDR (DMA_ADDR),
    .RD_MASK  (RD_MASK),
    .WR_MASK  (WR_MASK)
  ) i_dec (
    .addr_i (bus_addr),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .dec_o  (dec)
  );

  always_comb begin
    ram_we = dec.wr_go && (dec.tgt == TGT_RAM);
    ram_re = dec.rd_go && (dec.tgt == TGT_RAM);
  end

  cbr_ram #(.AW(RAM_AW), .DW(DATA_W)) i_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (bus_addr[RAM_AW-1:0]),
    .wdata_i (bus_wdata),
    .rdata_o (ram_q)
  );

  cbr_dma_trig #(.DW(DATA_W)) i_dma (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .fire_i  (dec.dma),
    .data_i  (bus_wdata),
    .pulse_o (dma_start),
    .page_o  (dma_page)
  );

  // graphics and cartridge strobes in the request cycle
  always_comb begin
    gfx_idx    = bus_addr[REG_AW-1:0];
    gfx_rd     = dec.rd_go && (dec.tgt == TGT_GFX);
    gfx_wr     = dec.wr_go && (dec.tgt == TGT_GFX);
    gfx_wdata  = bus_wdata;
    cart_addr  = bus_addr;
    cart_rd    = dec.rd_go && (dec.tgt == TGT_CART);
    cart_wr    = dec.wr_go && (dec.tgt == TGT_CART);
    cart_wdata = bus_wdata;
  end

  // read-data select, captured in the request cycle
  always_comb begin
    sel_d = dec.rd_go ? dec.tgt : TGT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sel_q <= TGT_NONE;
    else          sel_q <= sel_d;
  end

  // sticky error flag
  always_comb begin
    err_d = err_q | dec.bad;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign access_err = err_q;

  always_comb begin
    case (sel_q)
      TGT_RAM:  bus_rdata = ram_q;
      TGT_GFX:  bus_rdata = gfx_rdata;
      TGT_CART: bus_rdata = cart_rdata;
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    access_err |=> access_err)
    else $error("error flag dropped");

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(access_err) |-> $past((bus_rd || bus_wr) && bus_addr >= REG_BASE && bus_addr < IO_BASE))
    else $error("error flag set outside graphics window");

  p_gfx_rd_perm_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    gfx_rd |-> RD_MASK[gfx_idx])
    else $error("read strobe on unreadable port");

  p_gfx_wr_perm_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    gfx_wr |-> WR_MASK[gfx_idx])
    else $error("write strobe on unwritable port");

  p_dma_cause_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    dma_start |-> $past(bus_wr && bus_addr == DMA_ADDR))
    else $error("DMA pulse without trigger write");

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(bus_rd) |-> (bus_rdata == '0))
    else $error("read data without preceding read");

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({gfx_rd, gfx_wr, cart_rd, cart_wr}))
    else $error("more than one external strobe");

endmodule

// File: tb/test_cpu_bus_router.sv
`timescale 1ns/1ps
module test_cpu_bus_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [2:0]  gfx_idx;
  logic        gfx_rd;
  logic        gfx_wr;
  logic [7:0]  gfx_wdata;
  logic [7:0]  gfx_rdata;
  logic        dma_start;
  logic [7:0]  dma_page;
  logic [15:0] cart_addr;
  logic        cart_rd;
  logic        cart_wr;
  logic [7:0]  cart_wdata;
  logic [7:0]  cart_rdata;
  logic        access_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  bit  err_m = 0;
  logic [7:0] mem_m [2048];

  always #2 clk = ~clk;

  cpu_bus_router i_cpu_bus_router (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gfx_idx(gfx_idx), .gfx_rd(gfx_rd), .gfx_wr(gfx_wr),
    .gfx_wdata(gfx_wdata), .gfx_rdata(gfx_rdata),
    .dma_start(dma_start), .dma_page(dma_page),
    .cart_addr(cart_addr), .cart_rd(cart_rd), .cart_wr(cart_wr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
    .access_err(access_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rd_ok(input int i);
    return (i == 2) || (i == 4) || (i == 7);
  endfunction

  function automatic bit wr_ok(input int i);
    return i != 2;
  endfunction

  function automatic bit in_gfx(input int a);
    return (a >= 'h2000) && (a < 'h4000);
  endfunction

  function automatic logic [7:0] gval(input int a);
    return 8'((a ^ (a >> 8) ^ 'hA5) & 'hFF);
  endfunction

  function automatic logic [7:0] cval(input int a);
    return 8'((a * 3 + (a >> 8)) & 'hFF);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    gfx_rdata = '0; cart_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11: state while held in reset
    chk(access_err == 0 && dma_start == 0 && bus_rdata == 0, "R11 in reset",
        {access_err, dma_start, bus_rdata}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    err_m = 0;
    chk(access_err == 0, "R11/R5 err after reset", access_err, 0);
    chk(dma_start == 0 && bus_rdata == 0, "R11 outputs after reset", {dma_start, bus_rdata}, 0);
    chk({gfx_rd, gfx_wr, cart_rd, cart_wr} == 0, "R11 strobes idle", {gfx_rd, gfx_wr, cart_rd, cart_wr}, 0);
  endtask

  task automatic do_read(input int a);
    int i;
    logic [7:0] exp;
    string req;
    bit g;
    i = a % 8;
    g = in_gfx(a);
    @(negedge clk);
    bus_addr = 16'(a); bus_rd = 1; bus_wr = 0;
    #1;
    chk(gfx_rd == (g && rd_ok(i)), g ? "R3 read strobe" : "R2 no gfx strobe", gfx_rd, g && rd_ok(i));
    if (g) chk(gfx_idx == 3'(i), "R2 index", gfx_idx, i);
    chk(cart_rd == (a >= 'h4020), "R8 cart read strobe", cart_rd, a >= 'h4020);
    if (a >= 'h4020) chk(cart_addr == 16'(a), "R8 cart addr", cart_addr, a);
    chk(gfx_wr == 0 && cart_wr == 0, "R2 no write on read", {gfx_wr, cart_wr}, 0);
    @(negedge clk);
    bus_rd = 0;
    gfx_rdata  = gval(a);
    cart_rdata = cval(a);
    #1;
    if (a < 'h2000) begin exp = mem_m[a % 2048]; req = "R1 RAM data"; end
    else if (g) begin exp = rd_ok(i) ? gval(a) : 8'h00; req = "R3 port data"; end
    else if (a >= 'h4020) begin exp = cval(a); req = "R8 cart data"; end
    else begin exp = 8'h00; req = "R7 io read zero"; end
    chk(bus_rdata == exp, req, bus_rdata, exp);
    if (g && !rd_ok(i)) err_m = 1;
    chk(access_err == err_m, "R5 error flag", access_err, err_m);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    int i;
    bit g;
    i = a % 8;
    g = in_gfx(a);
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = d; bus_wr = 1; bus_rd = 0;
    #1;
    chk(gfx_wr == (g && wr_ok(i)), g ? "R4 write strobe" : "R2 no gfx strobe", gfx_wr, g && wr_ok(i));
    if (g && wr_ok(i)) chk(gfx_idx == 3'(i) && gfx_wdata == d, "R2 index/data", {gfx_idx, gfx_wdata}, {3'(i), d});
    chk(cart_wr == (a >= 'h4020), "R8 cart write strobe", cart_wr, a >= 'h4020);
    if (a >= 'h4020) chk(cart_addr == 16'(a) && cart_wdata == d, "R8 cart addr/data", cart_addr, a);
    chk(gfx_rd == 0 && cart_rd == 0, "R7 no read on write", {gfx_rd, cart_rd}, 0);
    @(negedge clk);
    bus_wr = 0;
    #1;
    chk(dma_start == (a == 'h4014), "R6/R7 dma pulse", dma_start, a == 'h4014);
    if (a == 'h4014) chk(dma_page == d, "R6 dma page", dma_page, d);
    chk(bus_rdata == 0, "R9 no data after write", bus_rdata, 0);
    if (g && !wr_ok(i)) err_m = 1;
    chk(access_err == err_m, "R5 error flag", access_err, err_m);
    if (a < 'h2000) mem_m[a % 2048] = d;
  endtask

  initial begin
    do_reset();

    // R1: write through one mirror, read through another
    for (int a = 0; a < 2048; a++)
      do_write(a + 'h800 * ((a >> 3) % 4), 8'((a * 7 + 3) & 'hFF));
    for (int a = 0; a < 2048; a++)
      do_read(a + 'h800 * (a % 4));
    do_read('h1FFF);

    // R7: io window reads and ignored writes, R6 DMA trigger
    for (int a = 'h4000; a < 'h4020; a++) do_read(a);
    for (int a = 'h4000; a < 'h4020; a++) if (a != 'h4014) do_write(a, 8'(a + 'h40));
    for (int a = 0; a < 32; a++) do_read(a);  // R7 RAM untouched by io writes
    do_write('h4014, 8'h3C);
    @(negedge clk); #1;
    chk(dma_start == 0, "R6 pulse one cycle", dma_start, 0);
    chk(dma_page == 8'h3C, "R6 page held", dma_page, 8'h3C);
    do_write('h4014, 8'hC7);
    do_read('h4014);
    chk(dma_start == 0, "R6 no pulse on read", dma_start, 0);
    do_read('h0014);  // R7 DMA write left RAM alone

    // R8: cartridge pass-through
    do_read('h4020); do_write('h4020, 8'h11);
    do_read('hFFFF); do_write('hFFFF, 8'hEE);
    for (int a = 'h4020; a < 'h10000; a += 'h0101) begin
      do_read(a);
      do_write(a, 8'(a >> 3));
    end

    // R2-R4: graphics window, legal accesses first, no error yet
    for (int a = 'h2000; a < 'h4000; a++) begin
      if (rd_ok(a % 8)) do_read(a);
      if (wr_ok(a % 8)) do_write(a, 8'(a ^ 'h5A));
    end
    chk(access_err == 0, "R5 clear after legal accesses", access_err, 0);
    // full sweep including forbidden ones (R3, R4, R5)
    for (int a = 'h2000; a < 'h4000; a++) begin
      do_read(a);
      do_write(a, 8'(a));
    end
    repeat (4) @(negedge clk);
    #1 chk(access_err == 1, "R5 sticky", access_err, 1);

    // R5: reset clears; forbidden write alone sets it
    do_reset();
    do_write('h2002, 8'h77);
    do_reset();
    do_read('h3FF8);   // index 0 read forbidden

    // R10: read and write together act as a write
    do_reset();
    @(negedge clk);
    bus_addr = 16'h0123; bus_wdata = 8'hC3; bus_rd = 1; bus_wr = 1;
    #1 chk({gfx_rd, cart_rd} == 0, "R10 no read strobe", {gfx_rd, cart_rd}, 0);
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    #1 chk(bus_rdata == 0, "R10 no read data", bus_rdata, 0);
    mem_m['h123] = 8'hC3;
    do_read('h1923);   // mirror of 0x123
    @(negedge clk);
    bus_addr = 16'h2004; bus_wdata = 8'h99; bus_rd = 1; bus_wr = 1;
    gfx_rdata = 8'hF0;
    #1 chk(gfx_rd == 0 && gfx_wr == 1, "R10 port write only", {gfx_rd, gfx_wr}, 2'b01);
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    #1 chk(bus_rdata == 0, "R10 port no data", bus_rdata, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule